// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Partial Reset

This block is a single-clock FIFO that stores up to 1,024 words of 36 bits. One clock, one write enable and one read enable move data. The read side has two timing personalities. In standard timing a read request copies the oldest word into the output register. In fall-through timing the oldest word is presented on the output with no request, and a read request consumes it. The personality is taken from a select input while the master reset is held, and it cannot change again until the next master reset.

Two threshold outputs warn early. One is raised when few words remain, and one is raised when little room remains. Both compare the fill state against offset values that arrive on input ports. Software or a neighbouring block supplies these values, and the FIFO does not store them.

There are two active-low synchronous resets. The master reset empties the FIFO, zeroes the output register and captures the timing personality. The partial reset empties the FIFO and zeroes the output register, but it leaves the captured personality untouched. This lets a datapath be flushed without being configured again.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low at a rising edge, the FIFO becomes empty and `dout` becomes all zeroes. This reset is held for at least four edges. After it, standard timing shows `rd_flag`=1 and `wr_flag`=0, and fall-through timing shows `rd_flag`=0 and `wr_flag`=1.
- R2: The value of `mode_sel` at the last rising edge with `mrst_n` low selects the timing: 0 is standard and 1 is fall-through. Later changes of `mode_sel`, including changes during a partial reset, have no effect until the next master reset.
- R3: While `prst_n` is low at a rising edge (and `mrst_n` is high), the FIFO becomes empty and `dout` becomes all zeroes. The selected timing is kept.
- R4: In standard timing, a rising edge with `rd_en`=1 on a non-empty FIFO places the oldest word on `dout` after that edge. `rd_flag`=1 exactly when 0 words are stored. `wr_flag`=1 exactly when 1,024 words are stored.
- R5: In fall-through timing, a word written into an empty FIFO appears on `dout`, with `rd_flag`=1, after the second rising edge that follows its write, without any `rd_en`. A rising edge with `rd_en`=1 while `rd_flag`=1 replaces it with the next word, or drops `rd_flag` to 0 if no word is left.
- R6: In fall-through timing, `wr_flag`=1 while the storage array has a free slot. The total capacity is 1,025 words: 1,024 in the array plus 1 in the output register.
- R7: Words are written only on rising edges with `wr_en`=1, and are read only on rising edges with `rd_en`=1 (standard) or presented as in R5 (fall-through). With both enables low, `dout` does not change.
- R8: A write while the array is full is discarded. A read while nothing is available (standard: 0 stored; fall-through: `rd_flag`=0) is discarded and leaves `dout` unchanged.
- R9: In standard timing, a rising edge with both enables high, on a FIFO that is neither empty nor full, performs the write and the read. The stored count is unchanged.
- R10: `almost_empty`=1 exactly when the fill level is at most `x_ofs`. The fill level is the words in the array, plus 1 for a presented word in fall-through timing.
- R11: `almost_full`=1 exactly when 1,024 minus the words in the array is at most `y_ofs`.
- R12: Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| mode_sel | input | 1 | Timing select, captured during master reset (1 = fall-through) |
| x_ofs | input | 10 | Almost-empty offset |
| y_ofs | input | 10 | Almost-full offset |
| wr_en | input | 1 | Write enable |
| din | input | 36 | Write data |
| rd_en | input | 1 | Read enable |
| dout | output | 36 | Output register |
| rd_flag | output | 1 | Standard: FIFO empty; fall-through: output word ready |
| wr_flag | output | 1 | Standard: FIFO full; fall-through: input ready |
| almost_empty | output | 1 | Fill level at or below `x_ofs` |
| almost_full | output | 1 | Free array space at or below `y_ofs` |

## Verification
The assertions assume that `mrst_n` is low at the first rising edge, so that the state is defined before any clocked property is enabled. They also assume that both resets are clean, never-unknown levels. The offsets are taken to lie between 1 and 1,020, and the stimulus keeps to that range. Every input is changed one nanosecond after a rising edge, so no setup relation at the edge is ever in doubt. The bench holds each reset for at least four edges, and it changes `mode_sel` only in ways that test whether the captured timing sticks.

// File: rtl/dmfifo_pkg.sv
`timescale 1ns/1ps
package dmfifo_pkg;
    localparam int unsigned DEF_WIDTH = 36;
    localparam int unsigned DEF_DEPTH = 1024;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dmfifo_ram.sv
`timescale 1ns/1ps
module dmfifo_ram #(
    parameter int unsigned WIDTH = dmfifo_pkg::DEF_WIDTH,
    parameter int unsigned DEPTH = dmfifo_pkg::DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dmfifo_ctrl.sv
`timescale 1ns/1ps
module dmfifo_ctrl
    import dmfifo_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             mode_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [AW-1:0]    ram_raddr,
    output logic [CW-1:0]    ram_cnt,
    output logic             out_valid,
    output rd_mode_e         mode,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] dout;
        logic             ovalid;
        rd_mode_e         mode;
    } ctl_t;

    ctl_t st_d, st_q;
    logic is_full, is_empty, do_wr, do_pop, consume;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.cnt == CW'(DEPTH));
        is_empty = (st_q.cnt == '0);
        do_wr    = wr_en && !is_full;
        consume  = (st_q.mode == MODE_FWFT) && rd_en && st_q.ovalid;
        if (st_q.mode == MODE_STD) begin
            do_pop = rd_en && !is_empty;
        end else begin
            do_pop = !is_empty && (!st_q.ovalid || consume);
        end

        if (do_pop) begin
            st_d.dout   = ram_rdata;
            st_d.rptr   = step(st_q.rptr);
            st_d.ovalid = (st_q.mode == MODE_FWFT);
        end else if (consume) begin
            st_d.ovalid = 1'b0;
        end

        if (do_wr) begin
            st_d.wptr = step(st_q.wptr);
        end

        unique case ({do_wr, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        if (!mrst_n || !prst_n) begin
            st_d.wptr   = '0;
            st_d.rptr   = '0;
            st_d.cnt    = '0;
            st_d.dout   = '0;
            st_d.ovalid = 1'b0;
            if (!mrst_n) begin
                st_d.mode = rd_mode_e'(mode_sel);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ram_we    = do_wr && mrst_n && prst_n;
    assign ram_waddr = st_q.wptr;
    assign ram_raddr = st_q.rptr;
    assign ram_cnt   = st_q.cnt;
    assign out_valid = st_q.ovalid;
    assign mode      = st_q.mode;
    assign dout      = st_q.dout;

    // R1: master reset empties the FIFO and zeroes the output
    assert_mrst_clears_R1: assert property (@(posedge clk)
        !mrst_n |=> (st_q.cnt == '0 && st_q.dout == '0 && !st_q.ovalid
                     && st_q.wptr == '0 && st_q.rptr == '0));

    // R3: partial reset empties the FIFO but keeps the timing
    assert_prst_keeps_mode_R3: assert property (@(posedge clk)
        (mrst_n && !prst_n) |=> (st_q.cnt == '0 && st_q.dout == '0
                                 && $stable(st_q.mode)));

    // R2: timing is frozen outside master reset
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> $stable(st_q.mode));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        st_q.cnt <= CW'(DEPTH));

    assert_full_write_dropped_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (wr_en && st_q.cnt == CW'(DEPTH)) |=> $stable(st_q.wptr));

    assert_empty_read_dropped_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (st_q.mode == MODE_STD && rd_en && st_q.cnt == '0)
            |=> ($stable(st_q.rptr) && $stable(st_q.dout)));

    assert_rw_balance_R9: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (st_q.mode == MODE_STD && wr_en && rd_en && st_q.cnt != '0
         && st_q.cnt != CW'(DEPTH)) |=> $stable(st_q.cnt));

    assert_fwft_hold_R5: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (st_q.mode == MODE_FWFT && st_q.ovalid && !rd_en)
            |=> (st_q.ovalid && $stable(st_q.dout)));
endmodule

// File: rtl/dmfifo_flags.sv
`timescale 1ns/1ps
module dmfifo_flags
    import dmfifo_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  rd_mode_e      mode,
    input  logic [CW-1:0] ram_cnt,
    input  logic          out_valid,
    input  logic [AW-1:0] x_ofs,
    input  logic [AW-1:0] y_ofs,
    output logic          rd_flag,
    output logic          wr_flag,
    output logic          almost_empty,
    output logic          almost_full
);
    logic [CW-1:0] level, room;
    logic          arr_full, arr_empty;

    always_comb begin
        arr_full  = (ram_cnt == CW'(DEPTH));
        arr_empty = (ram_cnt == '0);
        level     = ram_cnt + ((mode == MODE_FWFT) ? CW'(out_valid) : '0);
        room      = CW'(DEPTH) - ram_cnt;
        if (mode == MODE_FWFT) begin
            rd_flag = out_valid;
            wr_flag = !arr_full;
        end else begin
            rd_flag = arr_empty;
            wr_flag = arr_full;
        end
        almost_empty = (level <= CW'(x_ofs));
        almost_full  = (room <= CW'(y_ofs));
    end

    // R4: in standard timing empty and full never coincide
    assert_std_flags_excl_R4: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (mode == MODE_STD) |-> !(rd_flag && wr_flag));

    // R10: with a nonzero offset an empty FIFO is almost empty
    assert_empty_is_low_R10: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (level == '0 && x_ofs != '0) |-> almost_empty);
endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/1ps
module dual_mode_fifo
    import dmfifo_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             mode_sel,
    input  logic [AW-1:0]    x_ofs,
    input  logic [AW-1:0]    y_ofs,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    output logic [WIDTH-1:0] dout,
    output logic             rd_flag,
    output logic             wr_flag,
    output logic             almost_empty,
    output logic             almost_full
);
    logic             ram_we;
    logic [AW-1:0]    ram_waddr, ram_raddr;
    logic [WIDTH-1:0] ram_rdata;
    logic [CW-1:0]    ram_cnt;
    logic             out_valid;
    rd_mode_e         mode;

    dmfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (din),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    dmfifo_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .mode_sel  (mode_sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_raddr (ram_raddr),
        .ram_cnt   (ram_cnt),
        .out_valid (out_valid),
        .mode      (mode),
        .dout      (dout)
    );

    dmfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk          (clk),
        .mrst_n       (mrst_n),
        .prst_n       (prst_n),
        .mode         (mode),
        .ram_cnt      (ram_cnt),
        .out_valid    (out_valid),
        .x_ofs        (x_ofs),
        .y_ofs        (y_ofs),
        .rd_flag      (rd_flag),
        .wr_flag      (wr_flag),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );
endmodule

// File: tb/dual_mode_fifo_tb.sv
`timescale 1ns/1ps
module dual_mode_fifo_tb;
    logic        clk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        prst_n = 1'b1;
    logic        mode_sel = 1'b0;
    logic [9:0]  x_ofs = 10'd4;
    logic [9:0]  y_ofs = 10'd3;
    logic        wr_en = 1'b0;
    logic [35:0] din = '0;
    logic        rd_en = 1'b0;
    logic [35:0] dout;
    logic        rd_flag, wr_flag, almost_empty, almost_full;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dual_mode_fifo u_dut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
        .x_ofs(x_ofs), .y_ofs(y_ofs), .wr_en(wr_en), .din(din), .rd_en(rd_en),
        .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    function automatic logic [35:0] pat(input int s, input int i);
        logic [31:0] iv;
        iv = i;
        return {s[3:0], iv[15:0], ~iv[15:0]};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic master_reset(input logic m);
        mrst_n = 1'b0; mode_sel = m; wr_en = 1'b0; rd_en = 1'b0;
        repeat (5) tick();
        mrst_n = 1'b1;
        mode_sel = ~m;  // must not matter after release (R2)
    endtask

    task automatic t_reset_std();
        master_reset(1'b0);
        chk("R1 dout zero", dout, 36'h0);
        chk("R1 std empty", rd_flag, 1);
        chk("R1 std not full", wr_flag, 0);
        chk("R10 ae after reset", almost_empty, 1);
        chk("R11 af after reset", almost_full, 0);
    endtask

    task automatic t_std_rw();
        for (int i = 0; i < 5; i++) begin
            wr_en = 1'b1; din = pat(1, i); tick();
            if (i == 3) chk("R10 ae at level 4", almost_empty, 1);
        end
        wr_en = 1'b0;
        chk("R10 ae clear at level 5", almost_empty, 0);
        chk("R4 not empty", rd_flag, 0);
        tick();
        chk("R7 idle keeps dout", dout, 36'h0);
        for (int i = 0; i < 5; i++) begin
            rd_en = 1'b1; tick();
            chk("R12 std order", dout, pat(1, i));
        end
        rd_en = 1'b0;
        chk("R4 empty after drain", rd_flag, 1);
    endtask

    task automatic t_std_empty_read();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R8 empty read keeps dout", dout, pat(1, 4));
        chk("R8 still empty", rd_flag, 1);
        wr_en = 1'b1; din = pat(3, 0); tick(); wr_en = 1'b0;
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R8 pointer unmoved", dout, pat(3, 0));
    endtask

    task automatic t_std_simul();
        int bad;
        for (int i = 0; i < 3; i++) begin
            wr_en = 1'b1; din = pat(4, i); tick();
        end
        din = pat(4, 3); rd_en = 1'b1; tick();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 read served", dout, pat(4, 0));
        x_ofs = 10'd3; #1;
        chk("R9 level 3 at x=3", almost_empty, 1);
        x_ofs = 10'd2; #1;
        chk("R9 level 3 at x=2", almost_empty, 0);
        x_ofs = 10'd4;
        bad = 0;
        for (int i = 1; i < 4; i++) begin
            rd_en = 1'b1; tick();
            if (dout !== pat(4, i)) bad++;
        end
        rd_en = 1'b0;
        chk("R9 words after simultaneous", 36'(bad), 36'h0);
        chk("R9 exactly empty", rd_flag, 1);
    endtask

    task automatic t_std_fill();
        int bad;
        for (int i = 0; i < 1024; i++) begin
            wr_en = 1'b1; din = pat(1, i); tick();
            if (i + 1 == 1020) chk("R11 af at free 4", almost_full, 0);
            if (i + 1 == 1021) chk("R11 af at free 3", almost_full, 1);
            if (i + 1 == 1023) chk("R4 not full at 1023", wr_flag, 0);
        end
        chk("R4 full at 1024", wr_flag, 1);
        din = pat(2, 0); tick(); wr_en = 1'b0;
        chk("R8 still full", wr_flag, 1);
        bad = 0;
        for (int i = 0; i < 1024; i++) begin
            rd_en = 1'b1; tick();
            if (dout !== pat(1, i)) bad++;
        end
        chk("R12 full drain order", 36'(bad), 36'h0);
        chk("R8 dropped word absent", rd_flag, 1);
        tick(); rd_en = 1'b0;
        chk("R8 empty read ignored", dout, pat(1, 1023));
    endtask

    task automatic t_partial_std();
        wr_en = 1'b1; din = pat(5, 0); tick(); din = pat(5, 1); tick(); wr_en = 1'b0;
        prst_n = 1'b0; mode_sel = 1'b1;
        repeat (4) tick();
        prst_n = 1'b1;
        chk("R3 dout zero", dout, 36'h0);
        chk("R3 empty std", rd_flag, 1);
        wr_en = 1'b1; din = pat(5, 7); tick(); wr_en = 1'b0; tick();
        chk("R2 still standard no fall", dout, 36'h0);
        chk("R2 std not empty", rd_flag, 0);
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R3 old words gone", dout, pat(5, 7));
    endtask

    task automatic t_reset_fwft();
        master_reset(1'b1);
        x_ofs = 10'd1;
        chk("R1 fwft dout zero", dout, 36'h0);
        chk("R1 fwft not ready", rd_flag, 0);
        chk("R1 fwft input ready", wr_flag, 1);
    endtask

    task automatic t_fwft_fall();
        wr_en = 1'b1; din = pat(6, 0); tick(); wr_en = 1'b0;
        chk("R5 not yet ready", rd_flag, 0);
        tick();
        chk("R5 ready after two edges", rd_flag, 1);
        chk("R5 word fell through", dout, pat(6, 0));
        chk("R10 fwft level 1", almost_empty, 1);
        wr_en = 1'b1; din = pat(6, 1); tick();
        chk("R10 fwft level 2", almost_empty, 0);
        din = pat(6, 2); tick(); wr_en = 1'b0; tick();
        chk("R7 fwft held without read", dout, pat(6, 0));
        rd_en = 1'b1; tick();
        chk("R5 next word", dout, pat(6, 1));
        tick();
        chk("R5 third word", dout, pat(6, 2));
        tick();
        chk("R5 drained", rd_flag, 0);
        tick(); rd_en = 1'b0;
        chk("R8 fwft read ignored", dout, pat(6, 2));
    endtask

    task automatic t_fwft_capacity();
        int taken, bad;
        taken = 0;
        for (int n = 0; n < 1100 && wr_flag; n++) begin
            wr_en = 1'b1; din = pat(7, taken); tick(); taken++;
        end
        wr_en = 1'b0;
        chk("R6 capacity 1025", 36'(taken), 36'd1025);
        chk("R11 fwft af at full", almost_full, 1);
        wr_en = 1'b1; din = pat(9, 0); tick(); wr_en = 1'b0;
        chk("R8 fwft no room", wr_flag, 0);
        bad = 0;
        for (int i = 0; i < 1025; i++) begin
            if (!rd_flag || dout !== pat(7, i)) bad++;
            rd_en = 1'b1; tick();
        end
        rd_en = 1'b0;
        chk("R12 fwft drain order", 36'(bad), 36'h0);
        chk("R8 fwft extra word absent", rd_flag, 0);
    endtask

    task automatic t_partial_fwft();
        wr_en = 1'b1; din = pat(8, 0); tick(); wr_en = 1'b0; tick();
        prst_n = 1'b0; mode_sel = 1'b0;
        repeat (4) tick();
        prst_n = 1'b1;
        chk("R3 fwft dout zero", dout, 36'h0);
        chk("R3 fwft kept not ready", rd_flag, 0);
        wr_en = 1'b1; din = pat(8, 5); tick(); wr_en = 1'b0; tick();
        chk("R3 fwft kept fall", dout, pat(8, 5));
        master_reset(1'b0);
        chk("R2 new mode standard", rd_flag, 1);
    endtask

    initial begin
        t_reset_std();
        t_std_rw();
        t_std_empty_read();
        t_std_simul();
        t_std_fill();
        t_partial_std();
        t_reset_fwft();
        t_fwft_fall();
        t_fwft_capacity();
        t_partial_fwft();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule